// File: doc/BRIEF.md
# Eight-Channel Baud Tick Generator Bank

The block holds eight independent rate generators, each of which turns a chosen input event stream into a slower stream of single-cycle ticks for a serial channel. A generator counts input events through an optional divide-by-16 prescaler and a 12-bit divide-by-(N+1) counter. Each time a full division completes, it emits one tick on its output bit, synchronous to the system clock. For UART use, the tick rate is set to sixteen times the bit rate, so that the receiver can oversample each bit.

The input event for each generator comes from one of three places: a baud tick input already in the system clock domain, or one of two asynchronous external clock pins. Each pin passes through a two-flop synchronizer and a rising-edge detector before any generator sees it. Every generator has its own 32-bit configuration word on a simple word-addressed bus. Generators 0 to 3 occupy four consecutive words of a first address group, and generators 4 to 7 occupy four consecutive words of a second group with its own base.

Top module: `baud_bank`

## Requirements
- R1: Generator g (g<4) sits at word address BASE_A+g (default 0x00) and generator g (g>=4) at BASE_B+g-4 (default 0x40); any other address reads as zero and a write to it changes no register.
- R2: Each configuration word reads back what was written, masked to its used bits (mask 0x0001DFFF); bit 13 and bits 31:17 read as zero.
- R3: Bits 12:1 hold the divisor field N; the generator emits one tick per N+1 counted events, so N=0 ticks on every event and N=4095 ticks once per 4096 events.
- R4: Bit 0 set inserts a divide-by-16 prescaler ahead of the counter, giving one tick per 16*(N+1) source events.
- R5: Bits 15:14 select the source: 00 the internal tick input base_tick_i, 01 ext_clk_i[0], 10 ext_clk_i[1], 11 no source (no ticks).
- R6: With bit 16 (enable) clear, the generator's tick output stays low whatever its inputs do.
- R7: Any write to a generator's word clears its counter and prescaler, so counting restarts from zero under the new settings.
- R8: With the internal source, the tick that completes a division is high for exactly one cycle, in the cycle after the base_tick_i event that completed it.
- R9: An external pin counts one event per rising edge after synchronization; a level held high for many cycles counts once.
- R10: After reset, all configuration words read zero and all tick outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_tick_i | input | 1 | Internal baud event, one-cycle strobe |
| ext_clk_i | input | 2 | Asynchronous external clock pins |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| tick_o | output | 8 | Per-generator tick outputs |

## Verification
The hardest situation to reach is a generator with a mix of settings: prescaler on, nonzero divisor, and an external source whose edges arrive through the synchronizer while other generators share the same streams. The stimulus rewrites all eight words with random settings while the inputs are quiet. It then fires random interleaved bursts on the internal strobe and both pins, and compares each output's tick count with floor(events/(P*(N+1))). Directed cases cover the 4096-event divisor, a restart in the middle of a count, a held-high pin, and the exact one-cycle latency.

// File: rtl/baud_bank_pkg.sv
package baud_bank_pkg;
  localparam int WORD_W  = 32;
  localparam int DIV_W   = 12;
  localparam int PRE_W   = 4;
  localparam int EN_BIT  = 16;
  localparam int SRC_LSB = 14;
  localparam int DIV_LSB = 1;
  localparam int P16_BIT = 0;
  localparam logic [WORD_W-1:0] CFG_MASK = 32'h0001_DFFF;

  typedef enum logic [1:0] {
    SRC_BASE = 2'b00,
    SRC_EXTA = 2'b01,
    SRC_EXTB = 2'b10,
    SRC_NONE = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic             en;
    src_sel_e         src;
    logic             div16;
    logic [DIV_W-1:0] div;
  } gen_cfg_t;

  function automatic gen_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
    gen_cfg_t c;
    c.en    = w[EN_BIT];
    c.src   = src_sel_e'(w[SRC_LSB+:2]);
    c.div16 = w[P16_BIT];
    c.div   = w[DIV_LSB+:DIV_W];
    return c;
  endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_bank_pkg::*;
#(
  parameter int GRP_SIZE = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_A = 8'h00,
  parameter logic [ADDR_W-1:0] BASE_B = 8'h40,
  localparam int NUM_GEN = 2 * GRP_SIZE,
  localparam int GRP_W   = $clog2(GRP_SIZE),
  localparam int IDX_W   = GRP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output gen_cfg_t          cfg_o [NUM_GEN],
  output logic [NUM_GEN-1:0] clr_o
);
  logic [WORD_W-1:0] word_q [NUM_GEN];
  logic hit_a, hit_b, hit;
  logic [IDX_W-1:0] idx;

  assign hit_a = addr_i[ADDR_W-1:GRP_W] == BASE_A[ADDR_W-1:GRP_W];
  assign hit_b = addr_i[ADDR_W-1:GRP_W] == BASE_B[ADDR_W-1:GRP_W];
  assign hit   = hit_a | hit_b;
  assign idx   = {hit_b, addr_i[GRP_W-1:0]};

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               word_q[g] <= '0;
      else if (we_i && hit && idx == IDX_W'(g))   word_q[g] <= wdata_i & CFG_MASK;
    end
    assign cfg_o[g] = unpack_cfg(word_q[g]);
    assign clr_o[g] = we_i && hit && idx == IDX_W'(g);
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = word_q[idx];
  end

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit) |=> (word_q[$past(idx)] == ($past(wdata_i) & CFG_MASK))); // R2
  AST_ONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o)); // R1
endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int NUM_EXT = 2,
  parameter int SYNC_N  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] pin_i,
  output logic [NUM_EXT-1:0] rise_o
);
  for (genvar p = 0; p < NUM_EXT; p++) begin : g_pin
    logic [SYNC_N-1:0] sync_q;
    logic              last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        last_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_N-2:0], pin_i[p]};
        last_q <= sync_q[SYNC_N-1];
      end
    end
    assign rise_o[p] = sync_q[SYNC_N-1] & ~last_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[p] |=> !rise_o[p]); // R9
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_bank_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  gen_cfg_t           cfg_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] ev_i,
  output logic               tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick_q;
  logic             ev, feed;

  always_comb begin
    unique case (cfg_i.src)
      SRC_BASE: ev = ev_i[0];
      SRC_EXTA: ev = ev_i[1];
      SRC_EXTB: ev = ev_i[2];
      default:  ev = 1'b0;
    endcase
  end

  assign feed = ev && (!cfg_i.div16 || pre_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i || !cfg_i.en) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (ev && cfg_i.div16) pre_q <= pre_q + 1'b1;
      if (feed) begin
        if (cnt_q == cfg_i.div) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;

  AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(cfg_i.en)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i || (cnt_q <= cfg_i.div)); // R3
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && pre_q == '0 && !tick_q)); // R7
  AST_TICK_FROM_EV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(ev)); // R8
endmodule

// File: rtl/baud_bank.sv
module baud_bank
  import baud_bank_pkg::*;
#(
  parameter int GRP_SIZE = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_A = 8'h00,
  parameter logic [ADDR_W-1:0] BASE_B = 8'h40,
  parameter int NUM_EXT  = 2,
  localparam int NUM_GEN = 2 * GRP_SIZE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_tick_i,
  input  logic [NUM_EXT-1:0] ext_clk_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic [NUM_GEN-1:0] tick_o
);
  gen_cfg_t           cfg [NUM_GEN];
  logic [NUM_GEN-1:0] clr;
  logic [NUM_EXT-1:0] ext_rise;
  logic [NUM_EXT:0]   ev;

  baud_regs #(
    .GRP_SIZE(GRP_SIZE), .ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .cfg_o(cfg), .clr_o(clr)
  );

  baud_ext_sync #(.NUM_EXT(NUM_EXT)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_clk_i), .rise_o(ext_rise)
  );

  assign ev = {ext_rise, base_tick_i};

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    baud_gen #(.NUM_SRC(NUM_EXT + 1)) u_gen (
      .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg[g]), .clr_i(clr[g]),
      .ev_i(ev), .tick_o(tick_o[g])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> tick_o == '0); // R10
endmodule

// File: tb/baud_bank_test.sv
module baud_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        base_tick = 0;
  logic [1:0]  ext_clk = 0;
  logic        we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  tick;

  int errors = 0, checks = 0, cycles = 0;
  int tcnt [8];
  int n_int, n_a, n_b;
  bit done = 0;

  baud_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(base_tick), .ext_clk_i(ext_clk),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tick_o(tick)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    for (int g = 0; g < 8; g++) tcnt[g] += int'(tick[g]);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] gaddr(input int g);
    return (g < 4) ? 8'(g) : 8'(8'h40 + g - 4);
  endfunction

  function automatic logic [31:0] mk(input bit en, input int src, input int div, input bit p16);
    return (32'(en) << 16) | (32'(src & 3) << 14) | (32'(div & 12'hFFF) << 1) | 32'(p16);
  endfunction

  function automatic int exp_ticks(input logic [31:0] w, input int ni, input int na, input int nb);
    int n, p;
    if (!w[16]) return 0;
    case (w[15:14])
      2'b00: n = ni;
      2'b01: n = na;
      2'b10: n = nb;
      default: return 0;
    endcase
    p = w[0] ? 16 : 1;
    return n / (p * (int'(w[12:1]) + 1));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts;
    for (int g = 0; g < 8; g++) tcnt[g] = 0;
    n_int = 0; n_a = 0; n_b = 0;
  endtask

  // one 6-cycle step: optional base strobe (1 cycle) and ext pulses (3 high, 3 low)
  task automatic step(input bit bi, input bit ba, input bit bb);
    @(negedge clk);
    base_tick = bi; ext_clk = {bb, ba};
    @(negedge clk); base_tick = 0;
    @(negedge clk);
    @(negedge clk); ext_clk = 0;
    idle(2);
    n_int += int'(bi); n_a += int'(ba); n_b += int'(bb);
  endtask

  logic [31:0] cfgw [8];
  logic [31:0] d;

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R10 reset state
    for (int g = 0; g < 8; g++) begin
      rd(gaddr(g), d);
      check("R10 reset word", d, 0);
    end
    check("R10 tick low", tick, 0);

    // R2 readback with mask
    for (int i = 0; i < 16; i++) begin
      int g = i % 8;
      logic [31:0] v = $urandom;
      wr(gaddr(g), v);
      rd(gaddr(g), d);
      check("R2 readback", d, v & 32'h0001_DFFF);
    end

    // R1 unmapped address
    wr(8'h00, 32'h0000_1234);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R1 unmapped read", d, 0);
    rd(8'h80, d); check("R1 unmapped read", d, 0);
    rd(8'h00, d); check("R1 gen0 untouched", d, 32'h0000_1234);
    wr(8'h43, 32'h0000_0ABC);
    rd(8'h43, d); check("R1 group B word 7", d, 32'h0000_0ABC);
    rd(8'h03, d); check("R1 group A word 3 distinct", d == 32'h0000_0ABC, 0);

    // R8 latency: gen0 internal, N=0; others off
    for (int g = 0; g < 8; g++) wr(gaddr(g), 0);
    wr(gaddr(0), mk(1, 0, 0, 0));
    idle(2);
    check("R8 idle before", tick[0], 0);
    base_tick = 1;
    @(negedge clk); base_tick = 0;
    check("R8 tick next cycle", tick[0], 1);
    @(negedge clk);
    check("R8 tick single cycle", tick[0], 0);

    // R3 max divisor: N=4095, 8192 events -> 2 ticks
    wr(gaddr(1), mk(1, 0, 4095, 0));
    idle(2); clear_counts();
    base_tick = 1;
    repeat (8191) @(negedge clk);
    check("R3 N=4095 before last event", tcnt[1], 1);
    @(negedge clk); base_tick = 0;
    idle(2);
    check("R3 N=4095 ticks", tcnt[1], 2);
    check("R3 N=0 ticks every event", tcnt[0], 8192);

    // R7 restart mid-count: N=3, 2 events, rewrite, 3 events -> 0, then 1 more -> 1
    wr(gaddr(2), mk(1, 0, 3, 0));
    clear_counts();
    step(1, 0, 0); step(1, 0, 0);
    wr(gaddr(2), mk(1, 0, 3, 0));
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R7 no tick after restart", tcnt[2], 0);
    step(1, 0, 0);
    check("R7 tick after 4 fresh events", tcnt[2], 1);

    // R6 disabled and R5 source 11
    wr(gaddr(3), mk(0, 0, 0, 0));
    wr(gaddr(4), mk(1, 3, 0, 0));
    clear_counts();
    for (int i = 0; i < 5; i++) step(1, 1, 1);
    check("R6 disabled no ticks", tcnt[3], 0);
    check("R5 source 11 no ticks", tcnt[4], 0);

    // R9 held-high pin counts once
    wr(gaddr(5), mk(1, 1, 0, 0));
    idle(4); clear_counts();
    ext_clk[0] = 1; idle(20); ext_clk[0] = 0; idle(20);
    check("R9 held level one tick", tcnt[5], 1);

    // R4 prescaler: N=1, div16, 64 events -> 2
    wr(gaddr(6), mk(1, 2, 1, 1));
    idle(4); clear_counts();
    for (int i = 0; i < 64; i++) step(0, 0, 1);
    check("R4 div16 ticks", tcnt[6], 2);

    // random configs against bench model (R3 R4 R5 R6 R9)
    for (int t = 0; t < 20; t++) begin
      for (int g = 0; g < 8; g++) begin
        cfgw[g] = mk(($urandom % 8) != 0, $urandom % 4, $urandom % 4, ($urandom % 4) == 0);
        wr(gaddr(g), cfgw[g]);
      end
      clear_counts();
      for (int s = 0; s < 150; s++) begin
        logic [2:0] r = 3'($urandom);
        step(r[0], r[1], r[2]);
      end
      idle(6);
      for (int g = 0; g < 8; g++)
        check("R3 R4 R5 R6 R9 random", tcnt[g], exp_ticks(cfgw[g], n_int, n_a, n_b));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule